// File: doc/BRIEF.md
# Serial Divider Configuration Port

This block receives divider settings over three slow serial wires (data, clock and load) and presents them to a synthesizer as parallel register values. It produces a 9-bit reference divider, a 10-bit feedback divider, a loop-bandwidth select bit, two test bits, and a flag that reports a committed frame with a test bit set. Every serial line is synchronised into the system clock domain, and the serial clock and load are then reduced to single-cycle edge events. All state is therefore updated by the system clock.

While load is low, the serial clock shifts bits into a 22-bit register and the outputs do not move. A rising load copies the whole register to the outputs in one step. While load stays high, each shifted bit also reaches the outputs directly. When load falls, the outputs freeze. Range checks on the divider values happen downstream.

Top module: `cfgsr_top`

## Requirements
- R1: After reset the outputs hold reference divider 1, feedback divider 32, bandwidth select 1 (normal), test bits 00 and error flag 0.
- R2: While load is low, each rising serial-clock edge shifts the data bit into the register, and none of the outputs change.
- R3: A low-to-high load transition copies all 22 register bits to the outputs at once.
- R4: After a high-to-low load transition the outputs keep their values whatever is shifted in afterwards.
- R5: While load is high, each rising serial-clock edge shifts the register, and the outputs take the new register value. The error flag is not updated by these shifts.
- R6: Frame order, first bit sent to last: bandwidth select, test bit 1, test bit 0, reference divider bit 8 down to bit 0, feedback divider bit 9 down to bit 0. In register bits this is [21] bandwidth, [20:19] test, [18:10] reference divider, [9:0] feedback divider.
- R7: When more than 22 bits are shifted before a commit, only the last 22 are kept.
- R8: On each commit the error flag becomes 1 if either test bit of the committed frame is 1. Otherwise it becomes 0.
- R9: Bandwidth select 1 means normal loop bandwidth and 0 means narrow. It is taken directly from the frame's first bit.
- R10: A load transition on the pins appears at the outputs after the third rising system-clock edge that follows it, and not after the second.
- R11: After reset the shift register holds the default frame, so a load pulse with no bits shifted leaves the reset values in place.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ser_clk | input | 1 | Serial clock, asynchronous |
| ser_dat | input | 1 | Serial data, asynchronous |
| ser_ld | input | 1 | Load/commit line, asynchronous |
| div_in_o | output | 9 | Reference divider value |
| div_fb_o | output | 10 | Feedback divider value |
| bw_normal_o | output | 1 | 1 selects normal loop bandwidth, 0 selects narrow |
| test_o | output | 2 | Test bits {T1,T0} |
| test_err_o | output | 1 | A committed frame had a test bit set |

## Verification
Each pin change passes through two synchroniser flops and an edge-detect flop. A shift, commit or pass-through result is therefore due on the third system-clock edge after the pin moves. For a commit, the bench checks on the falling edge after the second system-clock rise that the old value is still present, and after the third that the new value has arrived. For every other check, the driver holds each serial level for four cycles before the scoreboard entry is compared, which keeps each comparison clear of the edge on which the value changes. The scoreboard's expected frames come from the bench's own 22-bit shift model and from the field positions in R6.

// File: rtl/cfgsr_pkg.sv
package cfgsr_pkg;
  localparam int R_W     = 9;
  localparam int M_W     = 10;
  localparam int T_W     = 3;
  localparam int FRAME_W = T_W + R_W + M_W;

  // First field is the most significant, i.e. the first bit on the wire.
  typedef struct packed {
    logic [T_W-1:0] tst;   // [2] bandwidth select, [1:0] test bits
    logic [R_W-1:0] r;
    logic [M_W-1:0] m;
  } frame_t;

  localparam frame_t RESET_FRAME = '{tst: 3'b100, r: 9'd1, m: 10'd32};

  function automatic frame_t shift_in(frame_t cur, logic bit_in);
    return frame_t'({cur[FRAME_W-2:0], bit_in});
  endfunction

  function automatic logic test_bits_set(frame_t f);
    return |f.tst[T_W-2:0];
  endfunction
endpackage

// File: rtl/cfgsr_sync.sv
module cfgsr_sync #(
  parameter int W      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] async_i,
  output logic [W-1:0] lvl_o,
  output logic [W-1:0] rise_o
);
  localparam int CHAIN = STAGES + 1;

  for (genvar b = 0; b < W; b++) begin : g_bit
    logic [CHAIN-1:0] chain_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q <= '0;
      else        chain_q <= {chain_q[CHAIN-2:0], async_i[b]};
    end
    assign lvl_o[b]  = chain_q[STAGES-1];
    assign rise_o[b] = chain_q[STAGES-1] & ~chain_q[STAGES];

    p_rise_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
      rise_o[b] |=> !rise_o[b]);
  end
endmodule

// File: rtl/cfgsr_shift.sv
module cfgsr_shift
  import cfgsr_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   shift_en,
  input  logic   din,
  output frame_t sr_q,
  output frame_t sr_nxt
);
  assign sr_nxt = shift_in(sr_q, din);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        sr_q <= RESET_FRAME;
    else if (shift_en) sr_q <= sr_nxt;
  end

  p_shift_lsb_r2: assert property (@(posedge clk) disable iff (!rst_n)
    shift_en |=> sr_q[0] == $past(din));
  p_shift_body_r7: assert property (@(posedge clk) disable iff (!rst_n)
    shift_en |=> sr_q[FRAME_W-1:1] == $past(sr_q[FRAME_W-2:0]));
  p_shift_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !shift_en |=> $stable(sr_q));
endmodule

// File: rtl/cfgsr_hold.sv
module cfgsr_hold
  import cfgsr_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   commit,
  input  logic   pass,
  input  frame_t sr_q,
  input  frame_t sr_nxt,
  output frame_t out_q,
  output logic   err_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_q <= RESET_FRAME;
      err_q <= 1'b0;
    end else if (commit) begin
      out_q <= sr_q;
      err_q <= test_bits_set(sr_q);
    end else if (pass) begin
      out_q <= sr_nxt;
    end
  end

  p_commit_copy_r3: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> out_q == $past(sr_q));
  p_pass_follow_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (pass && !commit) |=> out_q == sr_q);
  p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!pass && !commit) |=> $stable(out_q));
  p_err_r8: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> err_q == ($past(sr_q[FRAME_W-2]) | $past(sr_q[FRAME_W-3])));
  p_err_keep_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !commit |=> $stable(err_q));
endmodule

// File: rtl/cfgsr_top.sv
module cfgsr_top
  import cfgsr_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           ser_clk,
  input  logic           ser_dat,
  input  logic           ser_ld,
  output logic [R_W-1:0] div_in_o,
  output logic [M_W-1:0] div_fb_o,
  output logic           bw_normal_o,
  output logic [1:0]     test_o,
  output logic           test_err_o
);
  localparam int IDX_DAT = 0;
  localparam int IDX_CLK = 1;
  localparam int IDX_LD  = 2;

  logic [2:0] lvl, rise;
  logic       shift_ev, commit_ev, pass_ev, dat_s;
  frame_t     sr_q, sr_nxt, out_q;

  cfgsr_sync #(.W(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .async_i({ser_ld, ser_clk, ser_dat}),
    .lvl_o  (lvl),
    .rise_o (rise)
  );

  assign dat_s     = lvl[IDX_DAT];
  assign shift_ev  = rise[IDX_CLK];
  assign commit_ev = rise[IDX_LD];
  assign pass_ev   = shift_ev & lvl[IDX_LD];

  cfgsr_shift u_shift (
    .clk     (clk),
    .rst_n   (rst_n),
    .shift_en(shift_ev),
    .din     (dat_s),
    .sr_q    (sr_q),
    .sr_nxt  (sr_nxt)
  );

  cfgsr_hold u_hold (
    .clk   (clk),
    .rst_n (rst_n),
    .commit(commit_ev),
    .pass  (pass_ev),
    .sr_q  (sr_q),
    .sr_nxt(sr_nxt),
    .out_q (out_q),
    .err_q (test_err_o)
  );

  assign div_in_o    = out_q.r;
  assign div_fb_o    = out_q.m;
  assign bw_normal_o = out_q.tst[T_W-1];
  assign test_o      = out_q.tst[T_W-2:0];

  p_low_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!lvl[IDX_LD] && !commit_ev) |=> $stable({div_in_o, div_fb_o, bw_normal_o, test_o}));
endmodule

// File: tb/test_cfgsr_top.sv
module test_cfgsr_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ser_clk = 1'b0, ser_dat = 1'b0, ser_ld = 1'b0;
  logic [8:0] div_in_o;
  logic [9:0] div_fb_o;
  logic bw_normal_o, test_err_o;
  logic [1:0] test_o;

  int n_vec = 0, n_bad = 0;
  bit done = 0;

  always #4 clk = ~clk;  // 125 MHz

  cfgsr_top i_cfgsr_top (.*);

  typedef struct { string req; logic [21:0] frm; logic err; } item_t;
  item_t sbq[$];
  event chk_ev;

  logic [21:0] mdl;  // bench shift-register model

  function automatic logic [21:0] mk(logic bw, logic [1:0] t, logic [8:0] r, logic [9:0] m);
    return {bw, t, r, m};
  endfunction

  function automatic logic [21:0] observed();
    return {bw_normal_o, test_o, div_in_o, div_fb_o};
  endfunction

  // monitor: pops expectations and compares with the ports
  always @(chk_ev) begin
    item_t it;
    while (sbq.size() > 0) begin
      it = sbq.pop_front();
      n_vec++;
      if (observed() !== it.frm || test_err_o !== it.err) begin
        n_bad++;
        $display("FAIL %s: got frame=%h err=%b expected frame=%h err=%b",
                 it.req, observed(), test_err_o, it.frm, it.err);
      end
    end
  end

  task automatic expect_now(string req, logic [21:0] f, logic e);
    item_t it;
    it.req = req; it.frm = f; it.err = e;
    sbq.push_back(it);
    @(negedge clk);
    -> chk_ev;
    @(negedge clk);
  endtask

  task automatic send_bit(logic b);
    ser_dat = b;
    repeat (4) @(negedge clk);
    ser_clk = 1'b1;
    repeat (4) @(negedge clk);
    ser_clk = 1'b0;
    repeat (4) @(negedge clk);
    mdl = {mdl[20:0], b};
  endtask

  task automatic send_frame(logic [21:0] f);
    for (int i = 21; i >= 0; i--) send_bit(f[i]);
  endtask

  task automatic load_rise();
    ser_ld = 1'b1;
    repeat (6) @(negedge clk);
  endtask

  task automatic load_fall();
    ser_ld = 1'b0;
    repeat (6) @(negedge clk);
  endtask

  logic [21:0] fa, fb, fc, fd, fe, cur;
  logic cur_err;

  initial begin
    fa = mk(1'b0, 2'b00, 9'd3,   10'd100);
    fb = mk(1'b1, 2'b00, 9'd511, 10'd1023);
    fc = mk(1'b1, 2'b00, 9'd5,   10'd40);
    fd = mk(1'b1, 2'b10, 9'd2,   10'd50);
    fe = mk(1'b1, 2'b00, 9'd7,   10'd77);
    mdl = mk(1'b1, 2'b00, 9'd1, 10'd32);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset values
    expect_now("R1", mk(1'b1, 2'b00, 9'd1, 10'd32), 1'b0);
    // R11 load pulse with nothing shifted
    load_rise(); load_fall();
    expect_now("R11", mk(1'b1, 2'b00, 9'd1, 10'd32), 1'b0);
    // R2 shifting with load low leaves outputs
    send_frame(fa);
    expect_now("R2", mk(1'b1, 2'b00, 9'd1, 10'd32), 1'b0);
    // R10 latency: old after two edges, new after third
    ser_ld = 1'b1;
    @(negedge clk); @(negedge clk);
    n_vec++;
    if (observed() !== mk(1'b1, 2'b00, 9'd1, 10'd32)) begin
      n_bad++;
      $display("FAIL R10: early update got %h expected %h", observed(), mk(1'b1, 2'b00, 9'd1, 10'd32));
    end
    @(negedge clk);
    n_vec++;
    if (observed() !== fa) begin
      n_bad++;
      $display("FAIL R10: not updated after third edge got %h expected %h", observed(), fa);
    end
    repeat (3) @(negedge clk);
    // R3/R6/R9 committed frame A, narrow bandwidth
    expect_now("R3", fa, 1'b0);
    n_vec++;
    if (bw_normal_o !== 1'b0 || div_in_o !== 9'd3 || div_fb_o !== 10'd100) begin
      n_bad++;
      $display("FAIL R9: bw=%b r=%0d m=%0d expected bw=0 r=3 m=100", bw_normal_o, div_in_o, div_fb_o);
    end
    load_fall();
    // R4 outputs latched after load fall
    send_frame(fb);
    expect_now("R4", fa, 1'b0);
    load_rise();
    expect_now("R6", fb, 1'b0);
    load_fall();
    // R7 overlong frame keeps the last 22 bits
    for (int i = 0; i < 8; i++) send_bit(1'b1);
    send_frame(fc);
    load_rise();
    expect_now("R7", fc, 1'b0);
    load_fall();
    // R8 error on test bit, then cleared by a clean frame
    send_frame(fd);
    load_rise();
    expect_now("R8", fd, 1'b1);
    load_fall();
    send_frame(fe);
    load_rise();
    expect_now("R8", fe, 1'b0);
    // R5 pass-through with load held high
    send_bit(1'b1);
    expect_now("R5", mdl, 1'b0);
    send_bit(1'b0);
    expect_now("R5", mdl, 1'b0);
    send_bit(1'b1);
    expect_now("R5", mdl, 1'b0);
    cur = mdl;
    cur_err = 1'b0;
    load_fall();
    send_bit(1'b0);
    expect_now("R4", cur, cur_err);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_vec++;
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule